// File: doc/BRIEF.md
# Dual-Channel Serial ADC Capture Engine

This block reads a two-channel converter whose serial port resembles SPI but does not follow it exactly. The converter has no chip-select line. Instead, a one-cycle pulse on the conversion output starts a conversion and also marks the start of the readout frame. The block then drives a gated serial clock, derived from the fast system clock, for a fixed burst of 36 pulses. During that burst it collects both channel results, each a 14-bit two's-complement word sent MSB first. When the burst ends it presents both words together with a one-cycle valid strobe.

Each frame starts with a one-cycle start request while the engine is idle. The serial clock stays at its idle level outside frames. The idle level is a parameter, because converter families differ on it. The converter updates its data output on the falling edge. The engine never clocks logic from the serial clock. It detects each rising edge of that clock in the system clock domain and shifts in the synchronised data bit on that detect.

Top module: `adc_dual_capture`

## Requirements
- R1: While the reset input is low, and until the first start request after it, the serial clock sits at its idle level, the conversion output is low, the valid strobe is low and both result outputs read zero. A reset during a frame aborts the frame.
- R2: A start request seen while idle produces exactly one conversion pulse, one system clock wide, in the next cycle. The serial clock is at its idle level during that pulse.
- R3: Each frame carries exactly 36 serial clock pulses, counted as rising edges. The serial clock is at its idle level between frames.
- R4: Each serial clock phase lasts SYS_DIV/2 system clocks, so with the default SYS_DIV of 50 a high phase lasts 25 cycles.
- R5: Counting rising edges of a frame from 1, the bits sampled at edges 3 to 16 form the channel-0 result and those at edges 21 to 34 form the channel-1 result, MSB first. Bits at edges 1–2, 17–20 and 35–36 are discarded.
- R6: After the last pulse of a frame, the valid strobe is high for exactly one cycle with both new results. The results hold their value until the next strobe.
- R7: A start request that arrives during a frame is ignored. It produces no second conversion pulse and no second frame.
- R8: The SCK_IDLE parameter sets the serial clock's idle level (default 0). The converter updates its data output on the falling edge, and the engine samples it on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_req | input | 1 | Request one conversion and readout frame |
| adc_miso | input | 1 | Serial data from the converter |
| adc_sck | output | 1 | Gated serial clock to the converter |
| adc_conv | output | 1 | Conversion-start pulse, also frames the readout |
| ch0_data | output | 14 | Channel-0 result, two's complement |
| ch1_data | output | 14 | Channel-1 result, two's complement |
| data_valid | output | 1 | One-cycle strobe marking new results |

## Verification
The checker assumes the following about the inputs:
- start_req is synchronous to the system clock.
- The converter changes adc_miso only on a serial-clock falling edge, so the data is stable across the two-stage synchroniser and the following rising-edge detect.

The bench keeps to these rules with a clocked converter model. The model restarts its bit index on each conversion pulse and advances one bit per observed falling edge. Each frame puts non-zero filler in the discarded bit times, so an off-by-one window shows up as a wrong result. The bench raises start requests only on falling system-clock edges.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } cap_state_t;

endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/adc_sck_gen.sv
// Gated serial clock: a half-period divider toggles a phase bit TOGGLES
// times per frame, then the clock rests at the idle level.
module adc_sck_gen #(
  parameter int unsigned HALF_DIV = 25,
  parameter logic        IDLE_LVL = 1'b0,
  parameter int unsigned TOGGLES  = 72
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise,
  output logic last
);

  localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned TOG_W = $clog2(TOGGLES + 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [TOG_W-1:0] tog_q, tog_d;
  logic             phase_q, phase_d;
  logic             sck_q;
  logic             tick;

  assign tick = run && (div_q == DIV_W'(HALF_DIV - 1));
  assign last = tick && (tog_q == TOG_W'(TOGGLES - 1));

  always_comb begin
    div_d   = div_q;
    tog_d   = tog_q;
    phase_d = phase_q;
    if (!run) begin
      div_d = '0;
      tog_d = '0;
    end else if (tick) begin
      div_d   = '0;
      tog_d   = tog_q + 1'b1;
      phase_d = ~phase_q;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      tog_q   <= '0;
      phase_q <= 1'b0;
      sck_q   <= IDLE_LVL;
    end else begin
      div_q   <= div_d;
      tog_q   <= tog_d;
      phase_q <= phase_d;
      sck_q   <= sck;
    end
  end

  // Phase 0 is the resting level; the pin level is the phase shifted by IDLE_LVL.
  assign sck  = phase_q ^ IDLE_LVL;
  // Rising-edge detect in the fast domain, one cycle after the pin rises.
  assign rise = sck & ~sck_q;

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_cap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic last_tog,
  output logic conv,
  output logic run,
  output logic done
);

  cap_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_req) state_d = ST_CONV;
      ST_CONV: state_d = ST_RUN;
      ST_RUN:  if (last_tog) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign conv = (state_q == ST_CONV);
  assign run  = (state_q == ST_RUN);
  assign done = (state_q == ST_DONE);

endmodule

// File: rtl/adc_shift_store.sv
// Counts detected rising edges, shifts each channel's window into its own
// shift register and copies all of them to the result registers on commit.
module adc_shift_store #(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned LEAD   = 2,
  parameter int unsigned SLOT   = 18,
  parameter int unsigned N_CH   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     rise,
  input  logic                     miso,
  input  logic                     commit,
  output logic [N_CH*DATA_W-1:0]   result,
  output logic                     valid
);

  localparam int unsigned FRAME = N_CH * SLOT;
  localparam int unsigned IDX_W = $clog2(FRAME + 1);

  logic [1:0]       miso_s;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             valid_d;

  always_comb begin
    idx_d = idx_q;
    if (clear) begin
      idx_d = '0;
    end else if (rise) begin
      idx_d = idx_q + 1'b1;
    end
    valid_d = commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miso_s <= 2'b00;
      idx_q  <= '0;
      valid  <= 1'b0;
    end else begin
      miso_s <= {miso_s[0], miso};
      idx_q  <= idx_d;
      valid  <= valid_d;
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    localparam int unsigned FIRST = ch * SLOT + LEAD;
    localparam int unsigned LAST  = FIRST + DATA_W - 1;

    logic [DATA_W-1:0] sh_q, sh_d;
    logic [DATA_W-1:0] res_q, res_d;
    logic              in_win;

    always_comb begin
      in_win = rise && (idx_q >= IDX_W'(FIRST)) && (idx_q <= IDX_W'(LAST));
      sh_d   = in_win ? {sh_q[DATA_W-2:0], miso_s[1]} : sh_q;
      res_d  = commit ? sh_q : res_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q  <= '0;
        res_q <= '0;
      end else begin
        sh_q  <= sh_d;
        res_q <= res_d;
      end
    end

    assign result[ch*DATA_W +: DATA_W] = res_q;
  end

endmodule

// File: rtl/adc_dual_capture.sv
module adc_dual_capture #(
  parameter int unsigned SYS_DIV    = 50,
  parameter logic        SCK_IDLE   = 1'b0,
  parameter int unsigned DATA_W     = 14,
  parameter int unsigned LEAD_BITS  = 2,
  parameter int unsigned TRAIL_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              adc_miso,
  output logic              adc_sck,
  output logic              adc_conv,
  output logic [DATA_W-1:0] ch0_data,
  output logic [DATA_W-1:0] ch1_data,
  output logic              data_valid
);

  localparam int unsigned N_CH     = 2;
  localparam int unsigned SLOT     = LEAD_BITS + DATA_W + TRAIL_BITS;
  localparam int unsigned PULSES   = N_CH * SLOT;
  localparam int unsigned TOGGLES  = 2 * PULSES;
  localparam int unsigned HALF_DIV = SYS_DIV / 2;

  logic                   rst_n_int;
  logic                   run, done, last_tog, rise;
  logic [N_CH*DATA_W-1:0] results;

  adc_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_int)
  );

  adc_frame_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start_req (start_req),
    .last_tog  (last_tog),
    .conv      (adc_conv),
    .run       (run),
    .done      (done)
  );

  adc_sck_gen #(
    .HALF_DIV (HALF_DIV),
    .IDLE_LVL (SCK_IDLE),
    .TOGGLES  (TOGGLES)
  ) u_sck (
    .clk   (clk),
    .rst_n (rst_n_int),
    .run   (run),
    .sck   (adc_sck),
    .rise  (rise),
    .last  (last_tog)
  );

  adc_shift_store #(
    .DATA_W (DATA_W),
    .LEAD   (LEAD_BITS),
    .SLOT   (SLOT),
    .N_CH   (N_CH)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clear  (adc_conv),
    .rise   (rise),
    .miso   (adc_miso),
    .commit (done),
    .result (results),
    .valid  (data_valid)
  );

  assign ch0_data = results[0 +: DATA_W];
  assign ch1_data = results[DATA_W +: DATA_W];

endmodule

// File: rtl/adc_cap_checker.sv
module adc_cap_checker #(
  parameter logic        SCK_IDLE = 1'b0,
  parameter int unsigned PULSES   = 36,
  parameter int unsigned DATA_W   = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sck,
  input logic              conv,
  input logic              valid,
  input logic [DATA_W-1:0] ch0,
  input logic [DATA_W-1:0] ch1
);

  logic        busy_q;
  logic        sck_prev_q;
  logic [15:0] rise_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      sck_prev_q <= SCK_IDLE;
      rise_cnt_q <= '0;
    end else begin
      sck_prev_q <= sck;
      if (conv) begin
        busy_q     <= 1'b1;
        rise_cnt_q <= '0;
      end else begin
        if (valid) busy_q <= 1'b0;
        if (sck && !sck_prev_q) rise_cnt_q <= rise_cnt_q + 1'b1;
      end
    end
  end

  p_conv_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv |=> !conv);

  p_conv_at_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv |-> (sck == SCK_IDLE));

  p_pulse_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (rise_cnt_q == 16'(PULSES)));

  p_sck_rests_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !conv) |-> (sck == SCK_IDLE));

  p_valid_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  p_results_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(ch0) && $stable(ch1)));

  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !conv);

endmodule

bind adc_dual_capture adc_cap_checker #(
  .SCK_IDLE (SCK_IDLE),
  .PULSES   (PULSES),
  .DATA_W   (DATA_W)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .sck   (adc_sck),
  .conv  (adc_conv),
  .valid (data_valid),
  .ch0   (ch0_data),
  .ch1   (ch1_data)
);

// File: tb/sim_adc_dual_capture.sv
module sim_adc_dual_capture;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME_BITS = 36;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_req;
  logic        adc_miso;
  logic        adc_sck;
  logic        adc_conv;
  logic [13:0] ch0_data;
  logic [13:0] ch1_data;
  logic        data_valid;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  // Converter model state
  logic [FRAME_BITS-1:0] frame_bits = '0;
  int                    bit_idx = 0;
  logic                  m_sck_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_dual_capture u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .adc_miso   (adc_miso),
    .adc_sck    (adc_sck),
    .adc_conv   (adc_conv),
    .ch0_data   (ch0_data),
    .ch1_data   (ch1_data),
    .data_valid (data_valid)
  );

  // Converter: restarts on the conversion pulse, moves to the next bit after each falling edge.
  always @(posedge clk) begin
    m_sck_prev <= adc_sck;
    if (adc_conv) bit_idx <= 0;
    else if (m_sck_prev && !adc_sck) bit_idx <= bit_idx + 1;
  end
  assign adc_miso = (bit_idx < FRAME_BITS) ? frame_bits[FRAME_BITS-1-bit_idx] : 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; start_req = 1'b0;
    repeat (4) @(negedge clk);
    check(adc_sck == 1'b0, "R1 R8 sck idle in reset", adc_sck, 0);
    check(adc_conv == 1'b0, "R1 conv low in reset", adc_conv, 0);
    check(data_valid == 1'b0, "R1 valid low in reset", data_valid, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(ch0_data == 14'h0 && ch1_data == 14'h0, "R1 results zero after reset",
          {ch0_data, ch1_data}, 0);
    check(adc_sck == 1'b0 && adc_conv == 1'b0, "R1 quiet after reset", {adc_sck, adc_conv}, 0);
  endtask

  task automatic t_frame(input logic [13:0] a, input logic [13:0] b, input bit poke_busy);
    int  rises = 0, convs = 0, hi_run = 0, hi_first = -1, cyc = 0;
    bit  got = 0, conv_sck_ok = 1;
    logic prev;
    // Filler bits are non-zero so a shifted window gives a wrong result.
    frame_bits = {2'b10, a, 2'b01, 2'b11, b, 2'b10};
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    prev = adc_sck;
    while (!got && cyc < 4000) begin
      if (adc_conv) begin
        convs++;
        if (adc_sck != 1'b0) conv_sck_ok = 0;
      end
      if (adc_sck && !prev) rises++;
      if (adc_sck) hi_run++;
      else begin
        if (prev && hi_first < 0) hi_first = hi_run;
        hi_run = 0;
      end
      if (data_valid) got = 1;
      if (poke_busy && cyc == 300) start_req = 1'b1;
      if (poke_busy && cyc == 301) start_req = 1'b0;
      prev = adc_sck;
      cyc++;
      if (!got) @(negedge clk);
    end
    check(got, "R6 valid strobe seen", got, 1);
    check(convs == 1, poke_busy ? "R7 one conv despite busy start" : "R2 one conv pulse", convs, 1);
    check(conv_sck_ok, "R2 sck idle during conv", conv_sck_ok, 1);
    check(rises == 36, "R3 pulses per frame", rises, 36);
    check(hi_first == 25, "R4 sck high phase cycles", hi_first, 25);
    check(ch0_data == a, "R5 channel 0 result", ch0_data, a);
    check(ch1_data == b, "R5 channel 1 result", ch1_data, b);
    @(negedge clk);
    check(data_valid == 1'b0, "R6 valid one cycle", data_valid, 0);
    check(adc_sck == 1'b0, "R3 R8 sck idle after frame", adc_sck, 0);
  endtask

  task automatic t_quiet_after(input logic [13:0] a, input logic [13:0] b);
    bit activity = 0, changed = 0;
    frame_bits = {FRAME_BITS{1'b1}};
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (adc_conv || adc_sck || data_valid) activity = 1;
      if (ch0_data != a || ch1_data != b) changed = 1;
    end
    check(!activity, "R7 no second frame after ignored start", activity, 0);
    check(!changed, "R6 results hold between strobes", changed, 0);
  endtask

  task automatic t_reset_mid_frame();
    frame_bits = {2'b10, 14'h1555, 2'b01, 2'b11, 14'h2AAA, 2'b10};
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    repeat (500) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(adc_sck == 1'b0 && adc_conv == 1'b0 && data_valid == 1'b0,
          "R1 outputs quiet on reset mid frame", {adc_sck, adc_conv, data_valid}, 0);
    check(ch0_data == 14'h0 && ch1_data == 14'h0, "R1 results cleared mid frame",
          {ch0_data, ch1_data}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    check(adc_sck == 1'b0 && data_valid == 1'b0, "R1 aborted frame stays idle",
          {adc_sck, data_valid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog R1 R3 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_frame(14'h2ABC, 14'h1234, 1'b0);
    t_frame(14'h2000, 14'h1FFF, 1'b0);   // most negative / most positive
    t_frame(14'h3FFF, 14'h0001, 1'b1);   // start request during frame
    t_quiet_after(14'h3FFF, 14'h0001);
    t_reset_mid_frame();
    t_frame(14'h0000, 14'h3FFF, 1'b0);
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule